// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retire

This block is a circular reorder buffer for an out-of-order core. Each instruction that issues takes the slot at the tail pointer, and the index of that slot becomes its rename tag. Reservation stations use that tag to name the producer of an operand. When a functional unit finishes, it writes its result, together with any exception flags, into the slot named by its tag. The result stays in the buffer until the instruction retires, and other instructions can read it by tag through a set of read ports while it waits there.

Retirement is strictly in program order and happens at the head pointer. Once the head slot is complete, its value and destination register go out on a register-file write port and the slot is freed. Exceptions are dealt with only at this point. A trap is taken after its instruction commits, so the register is still written and a trap flag is raised. A fault is taken before commit, so the register write is dropped and a flush empties the whole buffer. Head and tail each carry one wrap bit beyond the index, which is how a full buffer is told apart from an empty one.

Top module: `rob_core`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty, `disp_ready` is 1, `disp_tag` is 0, and `ret_we`, `ret_trap` and `flush` are all 0.
- R2: Accepted dispatches receive tags 0, 1, 2 … that wrap modulo DEPTH, and `disp_tag` always shows the tag the next dispatch will receive.
- R3: With DEPTH entries in flight and no retire in the current cycle, `disp_ready` is 0 and a dispatch request allocates nothing, so `disp_tag` does not move.
- R4: A read port reports ready=0 for an allocated tag that has not completed. From the cycle after a completion, it reports ready=1 and the value that was written.
- R5: Retire stalls (`ret_we`=0) while the head entry has not completed, even when younger entries have completed.
- R6: When the head entry is complete, in the same cycle `ret_we`=1 with that entry's destination register and value, entries retire in dispatch order, and the freed tag then reads ready=0.
- R7: When the buffer is full and the head retires in the same cycle, `disp_ready` is 1 and the new dispatch receives the tag being retired.
- R8: A head entry completed with the trap flag (`cmp_trap`=1) retires with `ret_we`=1 and `ret_trap`=1.
- R9: A head entry completed with the fault flag (`cmp_fault`=1) retires with `ret_we`=0 and `flush`=1, and dispatch is refused in that cycle. In the next cycle the buffer is empty, `disp_tag` is 0 and every read port reports ready=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| disp_valid | input | 1 | Dispatch request |
| disp_areg | input | AREG_W | Destination architectural register of the dispatching instruction |
| disp_ready | output | 1 | A dispatch is accepted this cycle |
| disp_tag | output | IDX_W | Tag given to the next dispatch (the tail index) |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | IDX_W | Tag of the completing instruction |
| cmp_value | input | DATA_W | Result value |
| cmp_fault | input | 1 | Completion carries a fault taken before commit |
| cmp_trap | input | 1 | Completion carries a trap taken after commit |
| rd_tag | input | N_RD x IDX_W | Operand lookup tags, one per read port |
| rd_ready | output | N_RD | Looked-up entry is allocated and complete |
| rd_value | output | N_RD x DATA_W | Looked-up entry's value |
| ret_we | output | 1 | Register-file write enable from retire |
| ret_areg | output | AREG_W | Register-file write address |
| ret_value | output | DATA_W | Register-file write data |
| ret_trap | output | 1 | Retiring instruction raises a trap |
| flush | output | 1 | Fault at head: register write dropped, buffer emptied |
| empty | output | 1 | No entry is in flight |

## Verification
Dispatch and retire can happen in the same cycle. The hard case is a full buffer whose head has just completed, because the tail slot being allocated is the same slot the head is freeing. The vector table fills a four-entry buffer, completes the head out of order behind a younger entry, and keeps dispatch requested. It then checks that `disp_ready` stays 1, that the new tag equals the retiring tag, and that the next cycle still retires the correct entry. It also checks a full, non-retiring cycle, where the request must be refused and the tag must not move, and a fault cycle, where dispatch must be blocked while the flush is raised.

// File: rtl/rob_pkg.sv
// Package rob_pkg: types shared by the reorder-buffer modules.
// Assumes nothing beyond IEEE 1800-2017.
package rob_pkg;

    // Outcome of the head entry in the current cycle.
    typedef enum logic [1:0] {
        RK_NONE   = 2'd0,   // head absent or not yet complete
        RK_COMMIT = 2'd1,   // normal commit
        RK_TRAP   = 2'd2,   // commit, then trap
        RK_FAULT  = 2'd3    // no commit, flush
    } retire_kind_e;

endpackage

// File: rtl/rob_ptrs.sv
// Module rob_ptrs: head and tail pointers of the circular buffer.
// Each pointer has one wrap bit above the index. Equal pointers mean
// empty; equal index with different wrap bits means full.
// Assumes DEPTH is a power of two, so the index wraps naturally.
module rob_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             free,
    input  logic             flush,
    output logic [IDX_W-1:0] tail_idx,
    output logic [IDX_W-1:0] head_idx,
    output logic             full,
    output logic             empty
);
    logic [IDX_W:0] head_q;
    logic [IDX_W:0] tail_q;

    // Pointer update: a flush resets both pointers; otherwise each steps on its own event.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (free)  head_q <= head_q + 1'b1;
            if (alloc) tail_q <= tail_q + 1'b1;
        end
    end

    // Occupancy decode from the wrap bits.
    always_comb begin
        tail_idx = tail_q[IDX_W-1:0];
        head_idx = head_q[IDX_W-1:0];
        empty    = (head_q == tail_q);
        full     = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) && (head_q[IDX_W] != tail_q[IDX_W]);
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && alloc) |-> free);
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !free);
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
    p_tail_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !flush) |=> (tail_q == $past(tail_q) + 1'b1));

endmodule

// File: rtl/rob_store.sv
// Module rob_store: per-entry state (valid, done, fault, trap, register, value).
// It handles allocation, completion writes, freeing, the head view and the read ports.
// Assumes the caller never frees and completes the same entry in one cycle,
// and never completes a tag that is not allocated. Such a completion is ignored.
module rob_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int AREG_W = 5,
    parameter int N_RD   = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         alloc,
    input  logic [IDX_W-1:0]             alloc_idx,
    input  logic [AREG_W-1:0]            alloc_areg,
    input  logic                         free,
    input  logic [IDX_W-1:0]             head_idx,
    input  logic                         cmp_valid,
    input  logic [IDX_W-1:0]             cmp_idx,
    input  logic [DATA_W-1:0]            cmp_value,
    input  logic                         cmp_fault,
    input  logic                         cmp_trap,
    input  logic [N_RD-1:0][IDX_W-1:0]   rd_idx,
    output logic [N_RD-1:0]              rd_ready,
    output logic [N_RD-1:0][DATA_W-1:0]  rd_value,
    output logic                         head_valid,
    output logic                         head_done,
    output logic                         head_fault,
    output logic                         head_trap,
    output logic [AREG_W-1:0]            head_areg,
    output logic [DATA_W-1:0]            head_value
);
    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] done_q;
    logic [DEPTH-1:0] fault_q;
    logic [DEPTH-1:0] trap_q;
    logic [AREG_W-1:0] areg_q  [DEPTH];
    logic [DATA_W-1:0] value_q [DEPTH];
    logic cmp_hit;

    // A completion takes effect only on an allocated entry.
    assign cmp_hit = cmp_valid && valid_q[cmp_idx];

    // Status flags: freeing is applied first, so an allocation to the same slot wins.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
            done_q  <= '0;
            fault_q <= '0;
            trap_q  <= '0;
        end else begin
            if (free) valid_q[head_idx] <= 1'b0;
            if (cmp_hit) begin
                done_q[cmp_idx]  <= 1'b1;
                fault_q[cmp_idx] <= cmp_fault;
                trap_q[cmp_idx]  <= cmp_trap;
            end
            if (alloc) begin
                valid_q[alloc_idx] <= 1'b1;
                done_q[alloc_idx]  <= 1'b0;
                fault_q[alloc_idx] <= 1'b0;
                trap_q[alloc_idx]  <= 1'b0;
            end
        end
    end

    // Payload storage, no reset needed: it is only read while valid and done.
    always_ff @(posedge clk) begin
        if (cmp_hit) value_q[cmp_idx] <= cmp_value;
        if (alloc)   areg_q[alloc_idx] <= alloc_areg;
    end

    // Head view for the retire decision.
    always_comb begin
        head_valid = valid_q[head_idx];
        head_done  = done_q[head_idx];
        head_fault = fault_q[head_idx];
        head_trap  = trap_q[head_idx];
        head_areg  = areg_q[head_idx];
        head_value = value_q[head_idx];
    end

    // Operand read ports, one per lookup tag.
    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        assign rd_ready[p] = valid_q[rd_idx[p]] && done_q[rd_idx[p]];
        assign rd_value[p] = value_q[rd_idx[p]];
    end

    p_alloc_fresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> (valid_q[$past(alloc_idx)] && !done_q[$past(alloc_idx)]));
    p_free_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (free && !(alloc && alloc_idx == head_idx)) |=> !valid_q[$past(head_idx)]);

endmodule

// File: rtl/rob_retire.sv
// Module rob_retire: sorts the head entry into a retire outcome and gates dispatch.
// Purely combinational. Assumes the head fields come from the entry at the head pointer.
module rob_retire
    import rob_pkg::*;
(
    input  logic head_valid,
    input  logic head_done,
    input  logic head_fault,
    input  logic head_trap,
    input  logic full,
    output logic ret_we,
    output logic ret_trap,
    output logic flush,
    output logic disp_ready
);
    retire_kind_e kind;

    // Classify the head: a fault takes priority over a trap.
    always_comb begin
        if (!(head_valid && head_done)) kind = RK_NONE;
        else if (head_fault)            kind = RK_FAULT;
        else if (head_trap)             kind = RK_TRAP;
        else                            kind = RK_COMMIT;
    end

    // Outputs: a commit or trap writes the register; a fault flushes and blocks dispatch.
    always_comb begin
        ret_we     = (kind == RK_COMMIT) || (kind == RK_TRAP);
        ret_trap   = (kind == RK_TRAP);
        flush      = (kind == RK_FAULT);
        disp_ready = (kind != RK_FAULT) && (!full || ret_we);
    end

endmodule

// File: rtl/rob_core.sv
// Module rob_core: reorder buffer top. The tail index is the rename tag.
// Values are held until an in-order retire writes them to the register file.
// Assumes DEPTH is a power of two, at most one dispatch, completion and retire per cycle,
// and completions only to allocated tags.
module rob_core #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int AREG_W = 5,
    parameter int N_RD   = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        disp_valid,
    input  logic [AREG_W-1:0]           disp_areg,
    output logic                        disp_ready,
    output logic [IDX_W-1:0]            disp_tag,
    input  logic                        cmp_valid,
    input  logic [IDX_W-1:0]            cmp_tag,
    input  logic [DATA_W-1:0]           cmp_value,
    input  logic                        cmp_fault,
    input  logic                        cmp_trap,
    input  logic [N_RD-1:0][IDX_W-1:0]  rd_tag,
    output logic [N_RD-1:0]             rd_ready,
    output logic [N_RD-1:0][DATA_W-1:0] rd_value,
    output logic                        ret_we,
    output logic [AREG_W-1:0]           ret_areg,
    output logic [DATA_W-1:0]           ret_value,
    output logic                        ret_trap,
    output logic                        flush,
    output logic                        empty
);
    logic             disp_fire;
    logic [IDX_W-1:0] head_idx;
    logic             full;
    logic             head_valid, head_done, head_fault, head_trap;

    // An allocation happens only when requested and accepted.
    assign disp_fire = disp_valid && disp_ready;

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc    (disp_fire),
        .free     (ret_we),
        .flush    (flush),
        .tail_idx (disp_tag),
        .head_idx (head_idx),
        .full     (full),
        .empty    (empty)
    );

    rob_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AREG_W(AREG_W), .N_RD(N_RD)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .alloc      (disp_fire),
        .alloc_idx  (disp_tag),
        .alloc_areg (disp_areg),
        .free       (ret_we),
        .head_idx   (head_idx),
        .cmp_valid  (cmp_valid),
        .cmp_idx    (cmp_tag),
        .cmp_value  (cmp_value),
        .cmp_fault  (cmp_fault),
        .cmp_trap   (cmp_trap),
        .rd_idx     (rd_tag),
        .rd_ready   (rd_ready),
        .rd_value   (rd_value),
        .head_valid (head_valid),
        .head_done  (head_done),
        .head_fault (head_fault),
        .head_trap  (head_trap),
        .head_areg  (ret_areg),
        .head_value (ret_value)
    );

    rob_retire u_retire (
        .head_valid (head_valid),
        .head_done  (head_done),
        .head_fault (head_fault),
        .head_trap  (head_trap),
        .full       (full),
        .ret_we     (ret_we),
        .ret_trap   (ret_trap),
        .flush      (flush),
        .disp_ready (disp_ready)
    );

    p_flush_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!flush && !ret_we));

endmodule

// File: tb/test_rob_core.sv
`timescale 1ns/1ps
module test_rob_core;
    localparam int DEPTH = 4;
    localparam int DW    = 32;
    localparam int AW    = 5;
    localparam int IW    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0;
    logic [AW-1:0] disp_areg = '0;
    logic disp_ready;
    logic [IW-1:0] disp_tag;
    logic cmp_valid = 1'b0;
    logic [IW-1:0] cmp_tag = '0;
    logic [DW-1:0] cmp_value = '0;
    logic cmp_fault = 1'b0;
    logic cmp_trap = 1'b0;
    logic [1:0][IW-1:0] rd_tag = '0;
    logic [1:0] rd_ready;
    logic [1:0][DW-1:0] rd_value;
    logic ret_we;
    logic [AW-1:0] ret_areg;
    logic [DW-1:0] ret_value;
    logic ret_trap;
    logic flush;
    logic empty;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .DATA_W(DW), .AREG_W(AW), .N_RD(2)) i_rob_core (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_areg(disp_areg), .disp_ready(disp_ready), .disp_tag(disp_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
        .cmp_fault(cmp_fault), .cmp_trap(cmp_trap),
        .rd_tag(rd_tag), .rd_ready(rd_ready), .rd_value(rd_value),
        .ret_we(ret_we), .ret_areg(ret_areg), .ret_value(ret_value),
        .ret_trap(ret_trap), .flush(flush), .empty(empty)
    );

    typedef struct packed {
        logic          dv;
        logic [AW-1:0] da;
        logic          cv;
        logic [IW-1:0] ct;
        logic [DW-1:0] cval;
        logic          cf;
        logic          ctp;
        logic          erdy;
        logic [IW-1:0] etag;
        logic          ewe;
        logic [AW-1:0] eareg;
        logic [DW-1:0] eval;
        logic          etrap;
        logic          eflush;
    } vec_t;

    // Inputs of one cycle, then the outputs expected in that same cycle.
    localparam vec_t TBL [11] = '{
        '{1'b1, 5'd1, 1'b0, 2'd0, 32'h0,  1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 5'd0, 32'h0,  1'b0, 1'b0}, // R2 tag 0
        '{1'b1, 5'd2, 1'b0, 2'd0, 32'h0,  1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 5'd0, 32'h0,  1'b0, 1'b0}, // R2 tag 1
        '{1'b1, 5'd3, 1'b1, 2'd1, 32'h22, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 5'd0, 32'h0,  1'b0, 1'b0}, // R5 younger done first
        '{1'b1, 5'd4, 1'b1, 2'd0, 32'h11, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 5'd0, 32'h0,  1'b0, 1'b0}, // R5 head not yet done
        '{1'b1, 5'd5, 1'b0, 2'd0, 32'h0,  1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 5'd1, 32'h11, 1'b0, 1'b0}, // R7 full + retire
        '{1'b1, 5'd6, 1'b0, 2'd0, 32'h0,  1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 5'd2, 32'h22, 1'b0, 1'b0}, // R6 in order
        '{1'b1, 5'd7, 1'b1, 2'd2, 32'h33, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 5'd0, 32'h0,  1'b0, 1'b0}, // R3 full stall
        '{1'b1, 5'd7, 1'b0, 2'd0, 32'h0,  1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 5'd3, 32'h33, 1'b1, 1'b0}, // R8 trap commits
        '{1'b0, 5'd0, 1'b1, 2'd3, 32'h44, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 5'd0, 32'h0,  1'b0, 1'b0}, // R3 still full
        '{1'b1, 5'd8, 1'b0, 2'd0, 32'h0,  1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 5'd0, 32'h0,  1'b0, 1'b1}, // R9 fault flush
        '{1'b0, 5'd0, 1'b0, 2'd0, 32'h0,  1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 5'd0, 32'h0,  1'b0, 1'b0}  // R9 emptied
    };

    task automatic chk(input string lbl, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", lbl, act, exp);
        end
    endtask

    task automatic idle_inputs();
        disp_valid = 1'b0; disp_areg = '0;
        cmp_valid = 1'b0; cmp_tag = '0; cmp_value = '0; cmp_fault = 1'b0; cmp_trap = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        chk("R1 empty", empty, 1);
        chk("R1 disp_ready", disp_ready, 1);
        chk("R1 disp_tag", disp_tag, 0);
        chk("R1 ret_we", ret_we, 0);
        chk("R1 flush", flush, 0);

        // Vector table walk
        foreach (TBL[i]) begin
            @(negedge clk);
            disp_valid = TBL[i].dv; disp_areg = TBL[i].da;
            cmp_valid = TBL[i].cv; cmp_tag = TBL[i].ct; cmp_value = TBL[i].cval;
            cmp_fault = TBL[i].cf; cmp_trap = TBL[i].ctp;
            #2;
            chk("R3 R7 disp_ready", disp_ready, TBL[i].erdy);
            chk("R2 disp_tag", disp_tag, TBL[i].etag);
            chk("R5 R6 ret_we", ret_we, TBL[i].ewe);
            if (TBL[i].ewe) begin
                chk("R6 ret_areg", ret_areg, TBL[i].eareg);
                chk("R6 ret_value", ret_value, TBL[i].eval);
            end
            chk("R8 ret_trap", ret_trap, TBL[i].etrap);
            chk("R9 flush", flush, TBL[i].eflush);
        end

        // R4: read-port lookup before and after completion
        @(negedge clk); idle_inputs();
        disp_valid = 1'b1; disp_areg = 5'd9;
        #2 chk("R2 disp_tag after flush", disp_tag, 0);
        @(negedge clk); idle_inputs();
        rd_tag[0] = 2'd0;
        cmp_valid = 1'b1; cmp_tag = 2'd0; cmp_value = 32'hABCD;
        #2 chk("R4 not ready before completion", rd_ready[0], 0);
        @(negedge clk); idle_inputs();
        rd_tag[1] = 2'd0;
        #2;
        chk("R4 ready after completion", rd_ready[1], 1);
        chk("R4 read value", rd_value[1], 32'hABCD);
        chk("R6 ret_we", ret_we, 1);
        chk("R6 ret_areg", ret_areg, 9);
        chk("R6 ret_value", ret_value, 32'hABCD);
        @(negedge clk); idle_inputs();
        #2;
        chk("R6 freed tag not ready", rd_ready[0], 0);
        chk("R6 empty after retire", empty, 1);

        // R1: reset from a non-empty state
        @(negedge clk); disp_valid = 1'b1; disp_areg = 5'd10;
        @(negedge clk); idle_inputs(); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #2;
        chk("R1 empty after reset", empty, 1);
        chk("R1 disp_tag after reset", disp_tag, 0);
        chk("R1 disp_ready after reset", disp_ready, 1);
        chk("R1 ret_we after reset", ret_we, 0);

        // R9: fault at head drops the write and discards the completed younger entry
        @(negedge clk); disp_valid = 1'b1; disp_areg = 5'd11;
        @(negedge clk); disp_valid = 1'b1; disp_areg = 5'd12;
        @(negedge clk); idle_inputs();
        cmp_valid = 1'b1; cmp_tag = 2'd1; cmp_value = 32'h55;
        @(negedge clk); idle_inputs();
        cmp_valid = 1'b1; cmp_tag = 2'd0; cmp_value = 32'h66; cmp_fault = 1'b1;
        @(negedge clk); idle_inputs();
        disp_valid = 1'b1; disp_areg = 5'd13;
        rd_tag[0] = 2'd1;
        #2;
        chk("R9 flush raised", flush, 1);
        chk("R9 no register write", ret_we, 0);
        chk("R9 dispatch refused", disp_ready, 0);
        chk("R4 younger ready before flush", rd_ready[0], 1);
        @(negedge clk); idle_inputs();
        #2;
        chk("R9 younger cleared", rd_ready[0], 0);
        chk("R9 empty", empty, 1);
        chk("R9 disp_tag", disp_tag, 0);
        chk("R9 flush single cycle", flush, 0);

        finish_run();
    end
endmodule